// File: doc/BRIEF.md
# Multi-Address I2C Target Engine

This block is the target half of an I2C controller. It watches SCL and SDA and compares every address byte that follows a start condition against four programmable address slots. Each slot has its own mask, so one slot can answer for a whole group of addresses. When a byte matches, the block acknowledges it and then carries the rest of the transfer. It receives bytes into a data output. It shifts bytes out of a data input. It drives ACK or NACK, and it notices a stop or a repeated start.

Software drives the block through a pending-flag handshake. After each bus event the block raises a pending flag and posts an 8-bit status code. It then holds SCL low until software pulses the clear input. Software uses that window to read the received byte, or to supply the next byte to send, before the bus moves on. The acknowledge-enable input gates whether the block answers at all. When the block sends a byte, the same input also marks whether that byte is the last one.

Top module: `i2c_multi_target`

## Requirements
- R1: An address byte matches slot i when byte bits [7:1] equal slot bits [7:1] at every bit position whose mask bit is 0. A mask bit of 1 makes that position don't-care. Mask bit 0 has no effect. Byte bit 0 is the direction (0 write, 1 read). Slot i is held in bits [8i+7:8i] of each table input.
- R2: While `ack_en_i` is 0 when the eighth address bit completes, no address is acknowledged and no status is posted.
- R3: The byte 0x00 is a general call. It is acknowledged when bit 0 of any address slot is 1, and it posts 0x70. Each data byte after it that is acknowledged posts 0x90.
- R4: An own address with write direction posts 0x60. Each data byte received and acknowledged afterwards posts 0x80, and `rx_data_o` shows that byte (sent MSB first).
- R5: An own address with read direction posts 0xA8. On each clear the block loads `tx_data_i` and sends it MSB first. If the master acknowledges the byte, the block posts 0xB8.
- R6: If the master does not acknowledge a sent byte, the block posts 0xC0. If the byte was loaded while `ack_en_i` was 0 and the master acknowledges it, the block posts 0xC8. After either code SDA is released and the block is no longer addressed, so a following stop posts nothing.
- R7: A stop or a repeated start seen while addressed posts 0xA0. A stop seen while not addressed posts nothing.
- R8: Once a status is pending and SCL has gone low, the block holds SCL low until the clear. It never holds SCL without a pending status.
- R9: While nothing is pending, the status reads 0xF8. A clear pulse drops the pending flag on the next clock.
- R10: A data byte received while `ack_en_i` is 0 is not acknowledged and posts no status. The block then stops being addressed.
- R11: After reset nothing is pending, the status is 0xF8, and neither bus line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| scl_low_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_low_o | output | 1 | 1 pulls SDA low (ACK or a 0 data bit) |
| ack_en_i | input | 1 | Acknowledge enable; also marks the last byte to send |
| addr_tab_i | input | 8*N_SLOTS | Address slots; bit 0 of a slot enables general call |
| mask_tab_i | input | 8*N_SLOTS | Per-slot masks; a 1 bit is don't-care |
| tx_data_i | input | 8 | Byte to send, loaded on clear |
| clr_i | input | 1 | Pulse: clear the pending status and release SCL |
| pend_o | output | 1 | A status is waiting for software |
| status_o | output | 8 | Current status code |
| rx_data_o | output | 8 | Last byte received |

## Verification
A wrong state register would show up at the ports within one byte time. The block could acknowledge an address it should have ignored, or acknowledge where it should NACK. It could post the wrong code on the next rise of `pend_o`, or post a code where none was due. Because every rise of `pend_o` is matched against the code the bench queued for it, a stray or a missing event is reported at the clock on which the flag rises. A broken stretch or clear path appears on the same clock: SCL held with nothing pending, or the flag still set one cycle after a clear. A shift or bit-count fault corrupts the byte that the bench master reads back, or the value on `rx_data_o`, by the end of that byte.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      S_IDLE,
      S_ADDR,
      S_ADDR_ACK,
      S_RX_BIT,
      S_RX_ACK,
      S_RX_HOLD,
      S_TX_BIT,
      S_TX_ACK,
      S_TX_HOLD
   } tgt_state_e;

   localparam logic [7:0] CODE_WR_OWN  = 8'h60;
   localparam logic [7:0] CODE_WR_GC   = 8'h70;
   localparam logic [7:0] CODE_RX_OWN  = 8'h80;
   localparam logic [7:0] CODE_RX_GC   = 8'h90;
   localparam logic [7:0] CODE_END     = 8'hA0;
   localparam logic [7:0] CODE_RD_OWN  = 8'hA8;
   localparam logic [7:0] CODE_TX_ACK  = 8'hB8;
   localparam logic [7:0] CODE_TX_NACK = 8'hC0;
   localparam logic [7:0] CODE_TX_LAST = 8'hC8;
   localparam logic [7:0] CODE_NONE    = 8'hF8;

endpackage

// File: rtl/i2ct_line_sense.sv
module i2ct_line_sense #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_q,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_seen,
   output logic stop_seen
);

   logic scl_p, sda_p;

   generate
      if (STAGES == 0) begin : g_bypass
         assign scl_q = scl_i;
         assign sda_q = sda_i;
      end else begin : g_chain
         logic [STAGES-1:0] scl_ff, sda_ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff[0] <= scl_i;
               sda_ff[0] <= sda_i;
               for (int k = 1; k < STAGES; k++) begin
                  scl_ff[k] <= scl_ff[k-1];
                  sda_ff[k] <= sda_ff[k-1];
               end
            end
         end
         assign scl_q = scl_ff[STAGES-1];
         assign sda_q = sda_ff[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_q;
         sda_p <= sda_q;
      end
   end

   assign scl_rise   = scl_q & ~scl_p;
   assign scl_fall   = ~scl_q & scl_p;
   assign start_seen = scl_q & scl_p & sda_p & ~sda_q;
   assign stop_seen  = scl_q & scl_p & ~sda_p & sda_q;

endmodule

// File: rtl/i2ct_addr_match.sv
module i2ct_addr_match #(
   parameter int N_SLOTS = 4,
   parameter int BYTE_W  = 8,
   localparam int TAB_W  = N_SLOTS * BYTE_W
) (
   input  logic [TAB_W-1:0]  addr_tab,
   input  logic [TAB_W-1:0]  mask_tab,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              own_hit,
   output logic              gc_hit
);

   logic [N_SLOTS-1:0] slot_hit;
   logic [N_SLOTS-1:0] slot_gc;

   generate
      for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
         logic [BYTE_W-1:0] a_w, m_eff, diff;
         assign a_w   = addr_tab[i*BYTE_W +: BYTE_W];
         // the direction bit never takes part in the compare
         assign m_eff = mask_tab[i*BYTE_W +: BYTE_W] & {{(BYTE_W-1){1'b1}}, 1'b0};
         assign diff  = (rx_byte ^ a_w) & ~m_eff & {{(BYTE_W-1){1'b1}}, 1'b0};
         assign slot_hit[i] = (diff == '0);
         assign slot_gc[i]  = a_w[0];
      end
   endgenerate

   assign own_hit = |slot_hit;
   assign gc_hit  = (rx_byte == '0) && (|slot_gc);

endmodule

// File: rtl/i2ct_byte_engine.sv
module i2ct_byte_engine
   import i2ct_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_q,
   input  logic              sda_q,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_seen,
   input  logic              stop_seen,
   input  logic              ack_en,
   input  logic              own_hit,
   input  logic              gc_hit,
   input  logic              clr,
   input  logic [BYTE_W-1:0] tx_data,
   output logic [BYTE_W-1:0] shift_q,
   output logic              sda_drive,
   output logic              scl_hold,
   output logic              pend,
   output logic [7:0]        code,
   output logic [BYTE_W-1:0] rx_q
);

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   tgt_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic             gc_mode, rd_mode, last_tx, m_ack;
   logic             addressed, clr_now;

   assign addressed = (state != S_IDLE) && (state != S_ADDR);
   assign clr_now   = clr && pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         cnt       <= '0;
         shift_q   <= '0;
         sda_drive <= 1'b0;
         scl_hold  <= 1'b0;
         pend      <= 1'b0;
         code      <= CODE_NONE;
         rx_q      <= '0;
         gc_mode   <= 1'b0;
         rd_mode   <= 1'b0;
         last_tx   <= 1'b0;
         m_ack     <= 1'b0;
      end else begin
         if (clr_now) begin
            pend     <= 1'b0;
            scl_hold <= 1'b0;
            code     <= CODE_NONE;
         end else if (pend && !scl_q) begin
            scl_hold <= 1'b1;
         end

         if (start_seen) begin
            if (addressed) begin
               pend <= 1'b1;
               code <= CODE_END;
            end
            state     <= S_ADDR;
            cnt       <= '0;
            sda_drive <= 1'b0;
         end else if (stop_seen) begin
            if (addressed) begin
               pend <= 1'b1;
               code <= CODE_END;
            end
            state     <= S_IDLE;
            sda_drive <= 1'b0;
         end else begin
            unique case (state)
               S_IDLE: ;
               S_ADDR: begin
                  if (scl_rise) begin
                     shift_q <= {shift_q[BYTE_W-2:0], sda_q};
                     cnt     <= cnt + 1'b1;
                  end else if (scl_fall && cnt == FULL) begin
                     if (ack_en && gc_hit) begin
                        gc_mode   <= 1'b1;
                        rd_mode   <= 1'b0;
                        sda_drive <= 1'b1;
                        state     <= S_ADDR_ACK;
                     end else if (ack_en && own_hit) begin
                        gc_mode   <= 1'b0;
                        rd_mode   <= shift_q[0];
                        sda_drive <= 1'b1;
                        state     <= S_ADDR_ACK;
                     end else begin
                        state <= S_IDLE;
                     end
                  end
               end
               S_ADDR_ACK: begin
                  if (scl_fall) begin
                     sda_drive <= 1'b0;
                     pend      <= 1'b1;
                     cnt       <= '0;
                     if (gc_mode)      code <= CODE_WR_GC;
                     else if (rd_mode) code <= CODE_RD_OWN;
                     else              code <= CODE_WR_OWN;
                     state <= rd_mode ? S_TX_HOLD : S_RX_HOLD;
                  end
               end
               S_RX_HOLD: begin
                  if (clr_now) begin
                     state <= S_RX_BIT;
                     cnt   <= '0;
                  end
               end
               S_RX_BIT: begin
                  if (scl_rise) begin
                     shift_q <= {shift_q[BYTE_W-2:0], sda_q};
                     cnt     <= cnt + 1'b1;
                  end else if (scl_fall && cnt == FULL) begin
                     if (ack_en) begin
                        sda_drive <= 1'b1;
                        state     <= S_RX_ACK;
                     end else begin
                        state <= S_IDLE;
                     end
                  end
               end
               S_RX_ACK: begin
                  if (scl_fall) begin
                     sda_drive <= 1'b0;
                     rx_q      <= shift_q;
                     pend      <= 1'b1;
                     code      <= gc_mode ? CODE_RX_GC : CODE_RX_OWN;
                     state     <= S_RX_HOLD;
                  end
               end
               S_TX_HOLD: begin
                  if (clr_now) begin
                     shift_q   <= tx_data;
                     sda_drive <= ~tx_data[BYTE_W-1];
                     last_tx   <= ~ack_en;
                     cnt       <= '0;
                     state     <= S_TX_BIT;
                  end
               end
               S_TX_BIT: begin
                  if (scl_fall) begin
                     if (cnt == LAST) begin
                        sda_drive <= 1'b0;
                        state     <= S_TX_ACK;
                     end else begin
                        shift_q   <= {shift_q[BYTE_W-2:0], 1'b0};
                        sda_drive <= ~shift_q[BYTE_W-2];
                        cnt       <= cnt + 1'b1;
                     end
                  end
               end
               S_TX_ACK: begin
                  if (scl_rise) begin
                     m_ack <= ~sda_q;
                  end else if (scl_fall) begin
                     pend <= 1'b1;
                     if (!m_ack) begin
                        code  <= CODE_TX_NACK;
                        state <= S_IDLE;
                     end else if (last_tx) begin
                        code  <= CODE_TX_LAST;
                        state <= S_IDLE;
                     end else begin
                        code  <= CODE_TX_ACK;
                        state <= S_TX_HOLD;
                     end
                  end
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_multi_target.sv
module i2c_multi_target
   import i2ct_pkg::*;
#(
   parameter int N_SLOTS     = 4,
   parameter int SYNC_STAGES = 2,
   localparam int TAB_W      = N_SLOTS * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_low_o,
   output logic              sda_low_o,
   input  logic              ack_en_i,
   input  logic [TAB_W-1:0]  addr_tab_i,
   input  logic [TAB_W-1:0]  mask_tab_i,
   input  logic [BYTE_W-1:0] tx_data_i,
   input  logic              clr_i,
   output logic              pend_o,
   output logic [7:0]        status_o,
   output logic [BYTE_W-1:0] rx_data_o
);

   generate
      if (N_SLOTS < 1 || N_SLOTS > 16) begin : g_bad_slots
         $error("i2c_multi_target: N_SLOTS must lie in 1..16");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("i2c_multi_target: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic              scl_q, sda_q, scl_rise, scl_fall, start_seen, stop_seen;
   logic              own_hit, gc_hit;
   logic [BYTE_W-1:0] shift_q;

   i2ct_line_sense #(.STAGES(SYNC_STAGES)) u_sense (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_q      (scl_q),
      .sda_q      (sda_q),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_seen (start_seen),
      .stop_seen  (stop_seen)
   );

   i2ct_addr_match #(.N_SLOTS(N_SLOTS), .BYTE_W(BYTE_W)) u_match (
      .addr_tab (addr_tab_i),
      .mask_tab (mask_tab_i),
      .rx_byte  (shift_q),
      .own_hit  (own_hit),
      .gc_hit   (gc_hit)
   );

   i2ct_byte_engine u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_q      (scl_q),
      .sda_q      (sda_q),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_seen (start_seen),
      .stop_seen  (stop_seen),
      .ack_en     (ack_en_i),
      .own_hit    (own_hit),
      .gc_hit     (gc_hit),
      .clr        (clr_i),
      .tx_data    (tx_data_i),
      .shift_q    (shift_q),
      .sda_drive  (sda_low_o),
      .scl_hold   (scl_low_o),
      .pend       (pend_o),
      .code       (status_o),
      .rx_q       (rx_data_o)
   );

endmodule

// File: rtl/i2c_multi_target_chk.sv
module i2c_multi_target_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_low_o,
   input logic       sda_low_o,
   input logic       clr_i,
   input logic       pend_o,
   input logic [7:0] status_o
);

   // R8: SCL is only held while a status waits
   assert_hold_needs_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
      scl_low_o |-> pend_o);

   // R9: a clear drops the pending flag on the next clock
   assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && clr_i) |=> !pend_o);

   // R9: idle code while nothing is pending
   assert_idle_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_o |-> (status_o == 8'hF8));

   // R4: each newly posted code is one of the defined target codes
   assert_legal_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_o) |-> (status_o inside {8'h60, 8'h70, 8'h80, 8'h90, 8'hA0,
                                           8'hA8, 8'hB8, 8'hC0, 8'hC8}));

   // R6: SDA released once a send ends
   assert_release_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o && (status_o == 8'hC0 || status_o == 8'hC8)) |-> !sda_low_o);

endmodule

bind i2c_multi_target i2c_multi_target_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_low_o (scl_low_o),
   .sda_low_o (sda_low_o),
   .clr_i     (clr_i),
   .pend_o    (pend_o),
   .status_o  (status_o)
);

// File: tb/test_i2c_multi_target.sv
module test_i2c_multi_target;

   localparam int N  = 4;
   localparam int QT = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic scl_m = 1'b1, sda_m = 1'b1;
   logic scl_low, sda_low;
   wire  scl_l = scl_m & ~scl_low;
   wire  sda_l = sda_m & ~sda_low;

   logic            ack_en = 1'b0;
   logic [N*8-1:0]  atab = {8'h78, 8'h40, 8'hFF, 8'hA0};
   logic [N*8-1:0]  mtab = {8'h01, 8'h0E, 8'h00, 8'h00};
   logic [7:0]      txd = 8'h00;
   logic            clr = 1'b0;
   logic            pend;
   logic [7:0]      stat, rxd;

   int    nvec = 0, nbad = 0;
   bit    done = 0;
   logic  pend_d = 1'b0;
   byte unsigned exp_q[$];
   string        tag_q[$];

   i2c_multi_target #(.N_SLOTS(N)) i_i2c_multi_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_l), .sda_i(sda_l),
      .scl_low_o(scl_low), .sda_low_o(sda_low), .ack_en_i(ack_en),
      .addr_tab_i(atab), .mask_tab_i(mtab), .tx_data_i(txd), .clr_i(clr),
      .pend_o(pend), .status_o(stat), .rx_data_o(rxd)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic expect_code(input byte unsigned c, input string req);
      exp_q.push_back(c);
      tag_q.push_back(req);
   endtask

   // per-clock reference comparison
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (!pend) chk(stat == 8'hF8, "R9 idle status", stat, 8'hF8);
         if (scl_low) chk(pend == 1'b1, "R8 hold without pending", pend, 1);
         if (pend && !pend_d) begin
            if (exp_q.size() == 0) chk(1'b0, "R2/R7 unexpected status", stat, 0);
            else begin
               byte unsigned e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(stat == e, t, stat, e);
            end
         end
         pend_d = pend;
      end
   end

   task automatic ticks(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic wait_high();
      while (!scl_l) @(posedge clk);
   endtask

   task automatic m_start();
      sda_m = 1'b1; ticks(QT);
      scl_m = 1'b1; wait_high(); ticks(QT);
      sda_m = 1'b0; ticks(QT);
      scl_m = 1'b0; ticks(QT);
   endtask

   task automatic m_stop();
      sda_m = 1'b0; ticks(QT);
      scl_m = 1'b1; wait_high(); ticks(QT);
      sda_m = 1'b1; ticks(QT);
   endtask

   task automatic m_bit_out(input logic b);
      sda_m = b; ticks(QT);
      scl_m = 1'b1; wait_high(); ticks(QT);
      scl_m = 1'b0; ticks(QT);
   endtask

   task automatic m_bit_in(output logic b);
      sda_m = 1'b1; ticks(QT);
      scl_m = 1'b1; wait_high(); ticks(QT/2);
      b = sda_l; ticks(QT/2);
      scl_m = 1'b0; ticks(QT);
   endtask

   task automatic m_byte_out(input logic [7:0] v, output logic ack);
      for (int i = 7; i >= 0; i--) m_bit_out(v[i]);
      m_bit_in(ack);
   endtask

   task automatic m_byte_in(output logic [7:0] v, input logic nack);
      for (int i = 7; i >= 0; i--) begin
         logic b;
         m_bit_in(b);
         v[i] = b;
      end
      m_bit_out(nack);
   endtask

   task automatic sw_wait(input bit stretch, input string req);
      int t = 0;
      while (!pend && t < 3000) begin @(negedge clk); t++; end
      chk(pend == 1'b1, {req, " pending not raised"}, pend, 1);
      repeat (3) @(negedge clk);
      if (stretch) chk(scl_low == 1'b1 && scl_l == 1'b0, "R8 SCL stretched", scl_low, 1);
   endtask

   task automatic sw_clear(input logic [7:0] tx);
      @(negedge clk);
      txd = tx; clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      chk(pend == 1'b0, "R9 clear drops pending", pend, 0);
   endtask

   task automatic idle_check(input string req);
      ticks(20);
      @(negedge clk);
      chk(pend == 1'b0 && sda_low == 1'b0 && scl_low == 1'b0, req, pend, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      logic       a;
      logic [7:0] b;
      ticks(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(pend == 1'b0, "R11 pend", pend, 0);
      chk(stat == 8'hF8, "R11 status", stat, 8'hF8);
      chk(scl_low == 1'b0 && sda_low == 1'b0, "R11 lines", {scl_low, sda_low}, 0);

      // R2: acknowledge disabled, own address ignored
      m_start(); m_byte_out(8'hA0, a);
      chk(a == 1'b1, "R2 address NACK", a, 1);
      m_stop(); idle_check("R2 no status");
      ack_en = 1'b1;

      // R4: write to slot 0
      expect_code(8'h60, "R4 own write");
      m_start(); m_byte_out(8'hA0, a);
      chk(a == 1'b0, "R4 address ACK", a, 0);
      sw_wait(1, "R4"); sw_clear(8'h00);
      expect_code(8'h80, "R4 data");
      m_byte_out(8'h3C, a); sw_wait(1, "R4");
      chk(a == 1'b0 && rxd == 8'h3C, "R4 rx byte", rxd, 8'h3C);
      sw_clear(8'h00);
      expect_code(8'h80, "R4 data 2");
      m_byte_out(8'hC5, a); sw_wait(1, "R4");
      chk(rxd == 8'hC5, "R4 rx byte 2", rxd, 8'hC5);
      sw_clear(8'h00);
      expect_code(8'hA0, "R7 stop while addressed");
      m_stop(); sw_wait(0, "R7"); sw_clear(8'h00);

      // R1: masked slot and mask bit 0
      expect_code(8'h60, "R1 masked match");
      m_start(); m_byte_out(8'h4A, a);
      chk(a == 1'b0, "R1 masked ACK", a, 0);
      sw_wait(1, "R1"); sw_clear(8'h00);
      expect_code(8'hA0, "R7 stop");
      m_stop(); sw_wait(0, "R7"); sw_clear(8'h00);
      m_start(); m_byte_out(8'h50, a);
      chk(a == 1'b1, "R1 outside mask NACK", a, 1);
      m_stop(); idle_check("R1 no status");
      m_start(); m_byte_out(8'h7A, a);
      chk(a == 1'b1, "R1 mask bit0 ignored NACK", a, 1);
      m_stop(); idle_check("R1 no status 2");
      expect_code(8'h60, "R1 slot3 exact");
      m_start(); m_byte_out(8'h78, a);
      chk(a == 1'b0, "R1 slot3 ACK", a, 0);
      sw_wait(1, "R1"); sw_clear(8'h00);
      expect_code(8'hA0, "R7 stop");
      m_stop(); sw_wait(0, "R7"); sw_clear(8'h00);

      // R3: general call
      expect_code(8'h70, "R3 general call");
      m_start(); m_byte_out(8'h00, a);
      chk(a == 1'b0, "R3 gc ACK", a, 0);
      sw_wait(1, "R3"); sw_clear(8'h00);
      expect_code(8'h90, "R3 gc data");
      m_byte_out(8'h99, a); sw_wait(1, "R3");
      chk(rxd == 8'h99, "R3 gc rx byte", rxd, 8'h99);
      sw_clear(8'h00);
      expect_code(8'hA0, "R7 stop");
      m_stop(); sw_wait(0, "R7"); sw_clear(8'h00);

      // R5 / R6: read, ACK then last byte
      expect_code(8'hA8, "R5 own read");
      m_start(); m_byte_out(8'hA1, a);
      sw_wait(1, "R5"); sw_clear(8'hB6);
      expect_code(8'hB8, "R5 byte acked");
      m_byte_in(b, 1'b0); sw_wait(1, "R5");
      chk(b == 8'hB6, "R5 tx byte", b, 8'hB6);
      ack_en = 1'b0; sw_clear(8'h4D); ack_en = 1'b1;
      expect_code(8'hC8, "R6 last byte acked");
      m_byte_in(b, 1'b0); sw_wait(1, "R6");
      chk(b == 8'h4D, "R6 tx last byte", b, 8'h4D);
      chk(sda_low == 1'b0, "R6 SDA released", sda_low, 0);
      sw_clear(8'h00);
      m_stop(); idle_check("R6 stop after end posts nothing");

      // R6: master NACK
      expect_code(8'hA8, "R5 own read");
      m_start(); m_byte_out(8'hA1, a);
      sw_wait(1, "R5"); sw_clear(8'hF0);
      expect_code(8'hC0, "R6 master NACK");
      m_byte_in(b, 1'b1); sw_wait(1, "R6");
      chk(b == 8'hF0 && sda_low == 1'b0, "R6 NACK byte/release", b, 8'hF0);
      sw_clear(8'h00);
      m_stop(); idle_check("R7 stop unaddressed");

      // R7: repeated start while addressed
      expect_code(8'h60, "R4 own write");
      m_start(); m_byte_out(8'hA0, a);
      sw_wait(1, "R4"); sw_clear(8'h00);
      expect_code(8'h80, "R4 data");
      m_byte_out(8'h11, a); sw_wait(1, "R4"); sw_clear(8'h00);
      expect_code(8'hA0, "R7 repeated start");
      m_start(); sw_wait(1, "R7"); sw_clear(8'h00);
      expect_code(8'hA8, "R5 read after Sr");
      m_byte_out(8'hA1, a); sw_wait(1, "R5"); sw_clear(8'h81);
      expect_code(8'hC0, "R6 NACK after Sr");
      m_byte_in(b, 1'b1); sw_wait(1, "R6");
      chk(b == 8'h81, "R5 tx after Sr", b, 8'h81);
      sw_clear(8'h00);
      m_stop(); idle_check("R7 idle after");

      // R10: data byte with acknowledge disabled
      expect_code(8'h60, "R4 own write");
      m_start(); m_byte_out(8'hA0, a);
      sw_wait(1, "R4"); sw_clear(8'h00);
      ack_en = 1'b0;
      m_byte_out(8'h77, a);
      chk(a == 1'b1, "R10 data NACK", a, 1);
      ack_en = 1'b1;
      m_stop(); idle_check("R10 no status, not addressed");

      ticks(10);
      chk(exp_q.size() == 0, "R4 all expected codes seen", exp_q.size(), 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule